// File: doc/BRIEF.md
# Mode Register Load Decoder with Read Latency Timer

This block watches a DRAM-style command/address interface for mode register loads. The upper address bits pick the kind of load. When they are all zero, the load is a normal parameter update. When only bit 8 is set, the load also asks for a DLL reset. Any other pattern is reserved: the block ignores it and flags an error.

On an accepted load, the low seven address bits give three settings, which the block keeps: the burst length code, the burst type and the CAS latency. The block holds the CAS latency in half-clock units, so it can represent 2.5 clocks.

A separate read strobe starts a latency timer. The timer marks when the first read data is due. For a latency of 2 this is the rising clock edge two cycles after the read. For a latency of 2.5 it is the falling edge half a cycle after that. Reads may overlap, down to one read per clock.

Top module: `mode_load_decoder`

## Requirements
- R1: While reset is asserted, and after it is released with no load, the outputs are: burstCode = 3'd1 (burst of 2), burstType = 0 (sequential), casHalf = 5 (2.5 clocks). dllReset, modeError, casError and dataValid are all low.
- R2: A load with addr[ADDR_W-1:7] all zero stores the fields from the clock edge that samples loadValid. The fields are burstCode = addr[2:0] and burstType = addr[3] (0 sequential, 1 interleaved). The CAS code addr[6:4] is also taken, as R5 describes. No pulse is raised.
- R3: A load with addr[8] = 1 and every other bit from 7 to ADDR_W-1 zero stores the fields as in R2. It also raises dllReset for exactly the one cycle after the sampling edge.
- R4: A load with any other non-zero pattern in addr[ADDR_W-1:7] changes no stored field. It raises modeError for one cycle and does not raise dllReset or casError.
- R5: On an accepted load, CAS code 3'd2 sets casHalf = 4 and code 3'd6 sets casHalf = 5. Any other code leaves casHalf unchanged and raises casError for one cycle, while burstCode and burstType are still stored.
- R6: With casHalf = 4, a read sampled at rising edge n drives dataValid high from rising edge n+2 until rising edge n+3.
- R7: With casHalf = 5, a read sampled at rising edge n drives dataValid high from the falling edge between n+2 and n+3 until the falling edge between n+3 and n+4.
- R8: Reads on consecutive clock edges each produce their own valid window, so dataValid stays high across the whole run.
- R9: In a cycle with no load, burstCode, burstType and casHalf keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edges sample commands |
| rst_n | input | 1 | Asynchronous active-low reset |
| loadValid | input | 1 | Mode register load command strobe |
| addr | input | ADDR_W | Address bus carried with the load |
| readCmd | input | 1 | Read command strobe |
| burstCode | output | 3 | Stored burst length code (1=2, 2=4, 3=8) |
| burstType | output | 1 | Stored burst type (0 sequential, 1 interleaved) |
| casHalf | output | 3 | Stored CAS latency in half clocks (4 or 5) |
| dllReset | output | 1 | One-cycle DLL reset request |
| modeError | output | 1 | One-cycle reserved operating mode flag |
| casError | output | 1 | One-cycle reserved CAS code flag |
| dataValid | output | 1 | Marks the first read data of each read |

## Verification
The stored fields and the three pulses all change at the rising edge that samples the load. The bench updates its model at that edge and compares 5 ns later.

The read marker is due at either 2 or 2.5 clocks after the read. The bench therefore samples dataValid twice per cycle: 5 ns after the rising edge and 5 ns after the falling edge. It checks the early sample against the read from two or three edges back, depending on the latency. It checks the late sample against the read from two edges back. Both samples sit well away from any edge at which the output can move.

// File: rtl/mode_load_pkg.sv
package mode_load_pkg;

  localparam int LOW_W = 7;
  localparam logic [2:0] CAS_CODE_TWO  = 3'd2;
  localparam logic [2:0] CAS_CODE_HALF = 3'd6;
  localparam logic [2:0] RESET_BURST   = 3'd1;
  localparam logic       RESET_TYPE    = 1'b0;
  localparam logic       RESET_FRAC    = 1'b1;

  typedef struct packed {
    logic storeLow;
    logic storeCas;
    logic casFrac;
    logic dllHit;
    logic modeBad;
    logic casBad;
  } load_strobes_t;

endpackage

// File: rtl/mode_load_ctrl.sv
module mode_load_ctrl
  import mode_load_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              loadValid,
  input  logic [ADDR_W-1:0] addr,
  output load_strobes_t     strobes
);

  localparam int UP_W = ADDR_W - LOW_W;
  localparam logic [UP_W-1:0] DLL_PATTERN = UP_W'(2);

  logic [UP_W-1:0] upperBits;
  logic [2:0]      casField;
  logic            isNormal;
  logic            isDll;
  logic            accepted;
  logic            casKnown;

  always_comb begin
    upperBits = addr[ADDR_W-1:LOW_W];
    casField  = addr[6:4];
    isNormal  = (upperBits == '0);
    isDll     = (upperBits == DLL_PATTERN);
    accepted  = loadValid && (isNormal || isDll);
    casKnown  = (casField == CAS_CODE_TWO) || (casField == CAS_CODE_HALF);

    strobes.storeLow = accepted;
    strobes.storeCas = accepted && casKnown;
    strobes.casFrac  = (casField == CAS_CODE_HALF);
    strobes.dllHit   = loadValid && isDll;
    strobes.modeBad  = loadValid && !(isNormal || isDll);
    strobes.casBad   = accepted && !casKnown;
  end

endmodule

// File: rtl/mode_load_datapath.sv
module mode_load_datapath
  import mode_load_pkg::*;
#(
  parameter int CL_WHOLE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  load_strobes_t strobes,
  input  logic [3:0]    lowFields,
  input  logic          readCmd,
  output logic [2:0]    burstCode,
  output logic          burstType,
  output logic [2:0]    casHalf,
  output logic          dllReset,
  output logic          modeError,
  output logic          casError,
  output logic          dataValid
);

  localparam logic [2:0] WHOLE_HALVES = 3'(2 * CL_WHOLE);

  logic              fracQ;
  logic [CL_WHOLE:0] readPipe;
  logic              halfQ;

  // stored operating parameters and one-cycle pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burstCode <= RESET_BURST;
      burstType <= RESET_TYPE;
      fracQ     <= RESET_FRAC;
      dllReset  <= 1'b0;
      modeError <= 1'b0;
      casError  <= 1'b0;
    end else begin
      if (strobes.storeLow) begin
        burstCode <= lowFields[2:0];
        burstType <= lowFields[3];
      end
      if (strobes.storeCas) fracQ <= strobes.casFrac;
      dllReset  <= strobes.dllHit;
      modeError <= strobes.modeBad;
      casError  <= strobes.casBad;
    end
  end

  assign casHalf = WHOLE_HALVES | {2'b00, fracQ};

  // whole-cycle part of the latency: one stage per clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) readPipe[0] <= 1'b0;
    else        readPipe[0] <= readCmd;
  end

  for (genvar i = 1; i <= CL_WHOLE; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) readPipe[i] <= 1'b0;
      else        readPipe[i] <= readPipe[i-1];
    end
  end

  // half-cycle extension captured on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) halfQ <= 1'b0;
    else        halfQ <= readPipe[CL_WHOLE];
  end

  assign dataValid = fracQ ? halfQ : readPipe[CL_WHOLE];

endmodule

// File: rtl/mode_load_decoder.sv
module mode_load_decoder
  import mode_load_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadValid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              readCmd,
  output logic [2:0]        burstCode,
  output logic              burstType,
  output logic [2:0]        casHalf,
  output logic              dllReset,
  output logic              modeError,
  output logic              casError,
  output logic              dataValid
);

  load_strobes_t strobes;

  mode_load_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .loadValid (loadValid),
    .addr      (addr),
    .strobes   (strobes)
  );

  mode_load_datapath #(.CL_WHOLE(2)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .lowFields (addr[3:0]),
    .readCmd   (readCmd),
    .burstCode (burstCode),
    .burstType (burstType),
    .casHalf   (casHalf),
    .dllReset  (dllReset),
    .modeError (modeError),
    .casError  (casError),
    .dataValid (dataValid)
  );

endmodule

// File: rtl/mode_load_decoder_chk.sv
module mode_load_decoder_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              loadValid,
  input logic [ADDR_W-1:0] addr,
  input logic              readCmd,
  input logic [2:0]        burstCode,
  input logic              burstType,
  input logic [2:0]        casHalf,
  input logic              dllReset,
  input logic              modeError,
  input logic              casError,
  input logic              dataValid
);

  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cyc <= '0;
    else if (cyc != 3) cyc <= cyc + 2'd1;
  end

  assert_dll_from_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 0 && dllReset) |-> ($past(loadValid) && $past(addr[8])));

  assert_reserved_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 0 && modeError) |->
      ($stable(burstCode) && $stable(burstType) && $stable(casHalf) && !dllReset && !casError));

  assert_cas_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (casHalf == 3'd4) || (casHalf == 3'd5));

  assert_bad_cas_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 0 && casError) |-> $stable(casHalf));

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 0 && !$past(loadValid)) |->
      ($stable(burstCode) && $stable(burstType) && $stable(casHalf)));

  // R6, R7, R8: just before edge n+3, the marker reflects the read at edge n for either latency
  assert_read_marker_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 3) |-> (dataValid == $past(readCmd, 3)));

endmodule

bind mode_load_decoder mode_load_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mode_load_decoder_tb.sv
`timescale 1ns/1ps
module mode_load_decoder_tb;

  localparam int ADDR_W = 13;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              loadValid = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              readCmd = 1'b0;
  logic [2:0]        burstCode;
  logic              burstType;
  logic [2:0]        casHalf;
  logic              dllReset;
  logic              modeError;
  logic              casError;
  logic              dataValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [2:0] eBurst = 3'd1;
  logic       eType  = 1'b0;
  logic [2:0] eHalf  = 3'd5;
  logic       eDll = 1'b0, eMode = 1'b0, eCas = 1'b0;
  logic [3:0] hist = '0;

  always #10 clk = ~clk;

  mode_load_decoder #(.ADDR_W(ADDR_W)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input logic [5:0] up, input logic [2:0] cas,
                                           input logic bt, input logic [2:0] bl);
    return {up, cas, bt, bl};
  endfunction

  // model update for the rising edge that samples the current inputs
  task automatic modelEdge();
    logic [5:0] up;
    up = addr[ADDR_W-1:7];
    eDll = 1'b0; eMode = 1'b0; eCas = 1'b0;
    hist = {hist[2:0], readCmd};
    if (loadValid) begin
      if (up == 6'd0 || up == 6'd2) begin
        eBurst = addr[2:0];
        eType  = addr[3];
        if (addr[6:4] == 3'd2)      eHalf = 3'd4;
        else if (addr[6:4] == 3'd6) eHalf = 3'd5;
        else                        eCas = 1'b1;
        eDll = (up == 6'd2);
      end else begin
        eMode = 1'b1;
      end
    end
  endtask

  task automatic cycle(input logic ld, input logic [ADDR_W-1:0] a, input logic rd);
    logic expEarly;
    loadValid = ld; addr = a; readCmd = rd;
    @(posedge clk);
    modelEdge();
    #5;
    chk(burstCode == eBurst, "R2/R9 burstCode", burstCode, eBurst);
    chk(burstType == eType,  "R2/R9 burstType", burstType, eType);
    chk(casHalf == eHalf,    "R5/R9 casHalf",   casHalf,   eHalf);
    chk(dllReset == eDll,    "R3 dllReset",     dllReset,  eDll);
    chk(modeError == eMode,  "R4 modeError",    modeError, eMode);
    chk(casError == eCas,    "R5 casError",     casError,  eCas);
    expEarly = (eHalf == 3'd4) ? hist[2] : hist[3];
    chk(dataValid == expEarly, "R6/R7/R8 dataValid after rise", dataValid, expEarly);
    #10;
    chk(dataValid == hist[2], "R6/R7/R8 dataValid after fall", dataValid, hist[2]);
    #4;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #5;
    chk(burstCode == 3'd1, "R1 reset burstCode", burstCode, 1);
    chk(burstType == 1'b0, "R1 reset burstType", burstType, 0);
    chk(casHalf == 3'd5,   "R1 reset casHalf",   casHalf,   5);
    chk({dllReset, modeError, casError, dataValid} == 4'd0, "R1 reset pulses",
        {dllReset, modeError, casError, dataValid}, 0);
    #14;
    rst_n = 1'b1;

    // R1 hold, then R7 single read at CL 2.5
    cycle(0, '0, 0);
    cycle(0, '0, 1);
    repeat (5) cycle(0, '0, 0);
    // R2 normal load: CL2, interleaved, burst 4
    cycle(1, mk(6'd0, 3'd2, 1'b1, 3'd2), 0);
    cycle(0, '0, 1);                         // R6
    repeat (4) cycle(0, '0, 0);
    repeat (3) cycle(0, '0, 1);              // R8 back-to-back at CL2
    repeat (5) cycle(0, '0, 0);
    // R3 DLL reset, CL 2.5, burst 8 sequential
    cycle(1, mk(6'd2, 3'd6, 1'b0, 3'd3), 0);
    repeat (2) cycle(0, '0, 1);              // R8 at CL 2.5
    repeat (5) cycle(0, '0, 0);
    // R4 reserved upper patterns
    cycle(1, mk(6'd1, 3'd2, 1'b1, 3'd1), 0);
    cycle(1, mk(6'd3, 3'd2, 1'b1, 3'd2), 0);
    cycle(1, mk(6'd32, 3'd2, 1'b1, 3'd2), 0);
    cycle(1, mk(6'd6, 3'd2, 1'b1, 3'd2), 0);
    cycle(0, '0, 0);
    // R5 reserved CAS code keeps latency, stores burst fields
    cycle(1, mk(6'd0, 3'd3, 1'b1, 3'd2), 0);
    cycle(1, mk(6'd2, 3'd7, 1'b0, 3'd1), 0);
    cycle(0, '0, 0);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic ld;
      logic rd;
      logic [5:0] up;
      logic [2:0] cs;
      ld = ($urandom_range(0, 9) < 2);
      rd = ($urandom_range(0, 9) < 4);
      case ($urandom_range(0, 2))
        0: up = 6'd0;
        1: up = 6'd2;
        default: begin
          up = 6'($urandom_range(1, 63));
          if (up == 6'd2) up = 6'd3;
        end
      endcase
      case ($urandom_range(0, 3))
        0: cs = 3'd2;
        1: cs = 3'd6;
        default: cs = 3'($urandom_range(0, 7));
      endcase
      cycle(ld, mk(up, cs, 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7))), rd);
    end
    repeat (4) cycle(0, '0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule